// File: doc/BRIEF.md
# Host Port Interface Controller

This block is the slave side of a 16-bit host port. An external processor uses it to read and write a DSP's internal memory. The host strobes are synchronised to the core clock, and every data access becomes one request on an internal memory port. While a request is outstanding, a ready output tells the host to wait. The block also carries doorbell interrupts in both directions. After the port leaves reset it decides whether the core stays held, and a host write to a fixed address later releases it.

A static mode input selects how the host is wired. With the mode low, the host shares one 16-bit bus for data and register selection. Two select inputs pick the control word, the address register, or the data register with or without address post-increment. The 18-bit address is built from a 2-bit page field in the control word and 16 bits written over the bus. With the mode high, the host drives a separate 18-bit address bus, and every strobe is a data access at that address.

Top module: `hostport_ctrl`

## Requirements
- R1: In shared-bus mode, select code 2'b10 reaches the address register. A write loads its low 16 bits from the bus, and a read returns those 16 bits.
- R2: Select code 2'b01 is a data access at the current address. When the memory access completes, the 18-bit address increments by one and wraps from 0x3FFFF to 0x00000.
- R3: Select code 2'b11 is a data access at the current address that leaves the address unchanged.
- R4: A control-word write (select 2'b00) with bit 1 set gives the DSP a single-cycle doorbell pulse. Bit 1 always reads back as 0.
- R5: A DSP request sets the host doorbell. The host doorbell drives the active-low host interrupt and reads back in control bit 2. A host write with bit 2 set clears it, and a write with bit 2 clear leaves it unchanged.
- R6: Each data access issues one memory request, which is held with a stable address until it is acknowledged. Ready is low from the request until the acknowledge, and read data comes from the acknowledged word.
- R7: In separate-bus mode, every strobe is a memory access at the 18-bit address bus. The select inputs are ignored, the address register is untouched, and neither doorbell fires.
- R8: In shared-bus mode, the rising end of an address strobe with chip select active loads the address register from the bus, with no data access.
- R9: For three clocks after the synchronised port reset rises, strobe edges are ignored. While the port is in reset, no memory request is outstanding, and the address register, page field and host doorbell return to zero.
- R10: The core-hold output takes the level of the core reset input while the port is in reset. A host data write to address 0x0002F clears it.
- R11: Control bits 9:8 hold a page field, read back in the same place, that forms address bits 17:16 on every address-register load.
- R12: The two data strobes act as one. The access strobe is active when exactly one of them is low and chip select is low. Writes take effect at the strobe's end, and reads start at its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| port_rst_n | input | 1 | Active-low host port reset (asynchronous to clk) |
| mode_nonmux | input | 1 | 0 = shared bus, 1 = separate address bus |
| host_cs_n | input | 1 | Active-low chip select |
| host_as_n | input | 1 | Active-low address strobe (shared-bus mode) |
| host_ds1_n | input | 1 | Data strobe one, active low |
| host_ds2_n | input | 1 | Data strobe two, active low |
| host_rw | input | 1 | 1 = host read, 0 = host write |
| host_sel | input | 2 | Register select (shared-bus mode) |
| host_addr | input | 18 | Host address bus (separate-bus mode) |
| host_din | input | 16 | Data from host |
| host_dout | output | 16 | Data to host |
| host_rdy | output | 1 | High when the port can take the next access |
| host_int_n | output | 1 | Active-low interrupt to the host |
| core_rs_n | input | 1 | Core reset pin level sampled during port reset |
| core_hold | output | 1 | Keeps the core in reset while high |
| dsp_hint_set | input | 1 | DSP pulse that sets the host doorbell |
| dsp_int | output | 1 | Single-cycle doorbell pulse to the DSP |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with the acknowledge |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
A host strobe edge passes through two synchroniser flops and an edge flop. Its effect therefore appears after the third rising clock edge: a memory request, a register update, a doorbell pulse or new read data from a local register. Ready rises and read data appears on the edge at which the acknowledge is seen. With the bench's two-cycle memory, that is three clocks after the request. The bench samples only on falling clock edges. It checks the request and ready exactly at the third edge after the strobe falls. Elsewhere it waits four falling edges and then polls ready before sampling. The blackout check places a strobe end inside the three-clock window counted from the synchronised port-reset release.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_DATA_INC = 2'b01,
    SEL_ADDR     = 2'b10,
    SEL_DATA     = 2'b11
  } hsel_e;

  localparam int BIT_DSPINT = 1;
  localparam int BIT_HINT   = 2;
  localparam int PAGE_LO    = 8;
endpackage

// File: rtl/hpc_sync.sv
module hpc_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hpc_front.sv
module hpc_front #(
  parameter int BLANK  = 3,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic port_rst_n,
  input  logic cs_n,
  input  logic as_n,
  input  logic ds1_n,
  input  logic ds2_n,
  output logic port_ok,
  output logic stb_fall,
  output logic stb_rise,
  output logic as_rise
);
  localparam int CW = $clog2(BLANK + 1);

  logic          stb_raw_n, as_raw_n;
  logic [2:0]    sync_q;
  logic          stb_s, as_s;
  logic          stb_prev_q, as_prev_q;
  logic [CW-1:0] blank_q, blank_d;
  logic          acc_ok;

  // one combined strobe: active when exactly one data strobe is low
  assign stb_raw_n = (ds1_n ~^ ds2_n) | cs_n;
  assign as_raw_n  = as_n | cs_n;

  hpc_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b011)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({port_rst_n, as_raw_n, stb_raw_n}),
    .q     (sync_q)
  );

  assign port_ok = sync_q[2];
  assign as_s    = sync_q[1];
  assign stb_s   = sync_q[0];

  always_comb begin
    blank_d = blank_q;
    if (!port_ok)          blank_d = CW'(BLANK);
    else if (blank_q != 0) blank_d = blank_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q    <= CW'(BLANK);
      stb_prev_q <= 1'b1;
      as_prev_q  <= 1'b1;
    end else begin
      blank_q    <= blank_d;
      stb_prev_q <= stb_s;
      as_prev_q  <= as_s;
    end
  end

  assign acc_ok   = port_ok && (blank_q == '0);
  assign stb_fall = acc_ok &&  stb_prev_q && !stb_s;
  assign stb_rise = acc_ok && !stb_prev_q &&  stb_s;
  assign as_rise  = acc_ok && !as_prev_q  &&  as_s;
endmodule

// File: rtl/hpc_regs.sv
module hpc_regs
  import hpc_pkg::*;
#(
  parameter int          AW       = 18,
  parameter int          DW       = 16,
  parameter logic [AW-1:0] REL_ADDR = 18'h0002F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_ok,
  input  logic          stb_fall,
  input  logic          stb_rise,
  input  logic          as_rise,
  input  logic          mode_nonmux,
  input  logic          host_rw,
  input  logic [1:0]    host_sel,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_din,
  input  logic          core_rs_n,
  input  logic          dsp_hint_set,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] host_dout,
  output logic          host_rdy,
  output logic          host_int_n,
  output logic          dsp_int,
  output logic          core_hold,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int PW = AW - DW;

  logic [AW-1:0] addr_q, addr_d, maddr_q, maddr_d;
  logic [PW-1:0] page_q, page_d;
  logic [DW-1:0] dout_q, dout_d, wdata_q, wdata_d, ctrl_w;
  logic          hint_q, hint_d, hold_q, hold_d, req_q, req_d;
  logic          we_q, we_d, inc_q, inc_d, dint_q, dint_d;
  hsel_e         sel;

  assign sel = hsel_e'(host_sel);

  always_comb begin
    ctrl_w                   = '0;
    ctrl_w[BIT_HINT]         = hint_q;
    ctrl_w[PAGE_LO +: PW]    = page_q;
  end

  always_comb begin
    addr_d  = addr_q;  page_d  = page_q;  dout_d = dout_q;
    wdata_d = wdata_q; maddr_d = maddr_q; hint_d = hint_q;
    hold_d  = hold_q;  req_d   = req_q;   we_d   = we_q;
    inc_d   = inc_q;   dint_d  = 1'b0;
    if (!port_ok) begin
      addr_d = '0; page_d = '0; hint_d = 1'b0;
      hold_d = core_rs_n; req_d = 1'b0; inc_d = 1'b0;
    end else begin
      if (req_q) begin
        if (mem_ack) begin
          req_d = 1'b0;
          inc_d = 1'b0;
          if (!we_q) dout_d = mem_rdata;
          if (inc_q) addr_d = addr_q + AW'(1);
        end
      end else if (stb_fall && host_rw) begin
        if (mode_nonmux) begin
          req_d = 1'b1; we_d = 1'b0; maddr_d = host_addr; inc_d = 1'b0;
        end else begin
          case (sel)
            SEL_CTRL: dout_d = ctrl_w;
            SEL_ADDR: dout_d = addr_q[DW-1:0];
            default: begin
              req_d = 1'b1; we_d = 1'b0; maddr_d = addr_q;
              inc_d = (sel == SEL_DATA_INC);
            end
          endcase
        end
      end else if (stb_rise && !host_rw) begin
        if (mode_nonmux) begin
          req_d = 1'b1; we_d = 1'b1; maddr_d = host_addr;
          wdata_d = host_din; inc_d = 1'b0;
          if (host_addr == REL_ADDR) hold_d = 1'b0;
        end else begin
          case (sel)
            SEL_CTRL: begin
              dint_d = host_din[BIT_DSPINT];
              if (host_din[BIT_HINT]) hint_d = 1'b0;
              page_d = host_din[PAGE_LO +: PW];
            end
            SEL_ADDR: addr_d = {page_q, host_din};
            default: begin
              req_d = 1'b1; we_d = 1'b1; maddr_d = addr_q;
              wdata_d = host_din; inc_d = (sel == SEL_DATA_INC);
              if (addr_q == REL_ADDR) hold_d = 1'b0;
            end
          endcase
        end
      end else if (as_rise && !mode_nonmux) begin
        addr_d = {page_q, host_din};
      end
      if (mode_nonmux)       hint_d = 1'b0;
      else if (dsp_hint_set) hint_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; page_q <= '0; dout_q <= '0; wdata_q <= '0;
      maddr_q <= '0; hint_q <= 1'b0; hold_q <= 1'b1; req_q <= 1'b0;
      we_q <= 1'b0; inc_q <= 1'b0; dint_q <= 1'b0;
    end else begin
      addr_q <= addr_d; page_q <= page_d; dout_q <= dout_d; wdata_q <= wdata_d;
      maddr_q <= maddr_d; hint_q <= hint_d; hold_q <= hold_d; req_q <= req_d;
      we_q <= we_d; inc_q <= inc_d; dint_q <= dint_d;
    end
  end

  assign host_dout  = dout_q;
  assign host_rdy   = !req_q;
  assign host_int_n = !hint_q;
  assign dsp_int    = dint_q;
  assign core_hold  = hold_q;
  assign mem_req    = req_q;
  assign mem_we     = we_q;
  assign mem_addr   = maddr_q;
  assign mem_wdata  = wdata_q;
endmodule

// File: rtl/hostport_ctrl.sv
module hostport_ctrl #(
  parameter int            AW       = 18,
  parameter int            DW       = 16,
  parameter int            BLANK    = 3,
  parameter int            STAGES   = 2,
  parameter logic [AW-1:0] REL_ADDR = 18'h0002F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_rst_n,
  input  logic          mode_nonmux,
  input  logic          host_cs_n,
  input  logic          host_as_n,
  input  logic          host_ds1_n,
  input  logic          host_ds2_n,
  input  logic          host_rw,
  input  logic [1:0]    host_sel,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_rdy,
  output logic          host_int_n,
  input  logic          core_rs_n,
  output logic          core_hold,
  input  logic          dsp_hint_set,
  output logic          dsp_int,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  logic port_ok, stb_fall, stb_rise, as_rise;

  hpc_front #(.BLANK(BLANK), .STAGES(STAGES)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_rst_n (port_rst_n),
    .cs_n       (host_cs_n),
    .as_n       (host_as_n),
    .ds1_n      (host_ds1_n),
    .ds2_n      (host_ds2_n),
    .port_ok    (port_ok),
    .stb_fall   (stb_fall),
    .stb_rise   (stb_rise),
    .as_rise    (as_rise)
  );

  hpc_regs #(.AW(AW), .DW(DW), .REL_ADDR(REL_ADDR)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_ok      (port_ok),
    .stb_fall     (stb_fall),
    .stb_rise     (stb_rise),
    .as_rise      (as_rise),
    .mode_nonmux  (mode_nonmux),
    .host_rw      (host_rw),
    .host_sel     (host_sel),
    .host_addr    (host_addr),
    .host_din     (host_din),
    .core_rs_n    (core_rs_n),
    .dsp_hint_set (dsp_hint_set),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .host_dout    (host_dout),
    .host_rdy     (host_rdy),
    .host_int_n   (host_int_n),
    .dsp_int      (dsp_int),
    .core_hold    (core_hold),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata)
  );
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker #(
  parameter int            AW       = 18,
  parameter logic [AW-1:0] REL_ADDR = 18'h0002F
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_ok,
  input logic          mode_nonmux,
  input logic          dsp_int,
  input logic          core_hold,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr
);
  // R6: a pending request keeps its address and direction until acknowledged
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (port_ok && mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R6: an acknowledged request is withdrawn on the next cycle
  a_r6_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  // R4: the DSP doorbell is a single-cycle pulse
  a_r4_dspint_single: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_int |=> !dsp_int);

  // R7: no DSP doorbell while the separate-bus mode is held
  a_r7_no_dspint: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_nonmux) && mode_nonmux) |-> !dsp_int);

  // R9: no memory request survives port reset
  a_r9_idle_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !port_ok |=> !mem_req);

  // R10: the core is released only together with a write to the release address
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (port_ok && $past(port_ok) && $fell(core_hold)) |-> (mem_req && mem_we && mem_addr == REL_ADDR));
endmodule

bind hostport_ctrl hpc_checker #(.AW(AW), .REL_ADDR(REL_ADDR)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_ok     (port_ok),
  .mode_nonmux (mode_nonmux),
  .dsp_int     (dsp_int),
  .core_hold   (core_hold),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr)
);

// File: tb/test_hostport_ctrl.sv
module test_hostport_ctrl;
  localparam logic [1:0] S_CTRL = 2'b00, S_INC = 2'b01, S_ADDR = 2'b10, S_DATA = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n, port_rst_n, mode_nonmux, host_cs_n, host_as_n;
  logic        host_ds1_n, host_ds2_n, host_rw, core_rs_n, dsp_hint_set;
  logic [1:0]  host_sel;
  logic [17:0] host_addr;
  logic [15:0] host_din, host_dout;
  logic        host_rdy, host_int_n, core_hold, dsp_int;
  logic        mem_req, mem_we, mem_ack;
  logic [17:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit pick = 1'b0;

  always #2 clk = ~clk;

  hostport_ctrl i_hostport_ctrl (
    .clk(clk), .rst_n(rst_n), .port_rst_n(port_rst_n), .mode_nonmux(mode_nonmux),
    .host_cs_n(host_cs_n), .host_as_n(host_as_n), .host_ds1_n(host_ds1_n),
    .host_ds2_n(host_ds2_n), .host_rw(host_rw), .host_sel(host_sel),
    .host_addr(host_addr), .host_din(host_din), .host_dout(host_dout),
    .host_rdy(host_rdy), .host_int_n(host_int_n), .core_rs_n(core_rs_n),
    .core_hold(core_hold), .dsp_hint_set(dsp_hint_set), .dsp_int(dsp_int),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // memory model: acknowledge two cycles after a request is seen
  logic [15:0] arr [64];
  logic [63:0] written;
  logic [17:0] last_waddr;
  logic [15:0] last_wdata;
  int          lat, wr_cnt, dint_cnt;

  function automatic logic [15:0] pattern(input logic [17:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; lat <= 0; wr_cnt <= 0; written <= '0;
      mem_rdata <= '0; last_waddr <= '0; last_wdata <= '0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; lat <= 0;
    end else if (mem_req) begin
      if (lat == 1) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          arr[mem_addr[5:0]] <= mem_wdata;
          written[mem_addr[5:0]] <= 1'b1;
          last_waddr <= mem_addr; last_wdata <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata <= written[mem_addr[5:0]] ? arr[mem_addr[5:0]] : pattern(mem_addr);
        end
      end else lat <= lat + 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) dint_cnt <= 0;
    else if (dsp_int) dint_cnt <= dint_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_rdy();
    int n = 0;
    while (!host_rdy && n < 100) begin @(negedge clk); n++; end
    if (!host_rdy) chk("R6 ready timeout", 0, 1);
  endtask

  task automatic strobe(input logic v);
    if (pick) host_ds2_n = v; else host_ds1_n = v;
  endtask

  task automatic hacc(input logic rw, input logic [1:0] sel, input logic [15:0] d,
                      input logic [17:0] a, output logic [15:0] q);
    @(negedge clk);
    pick = ~pick;
    host_rw = rw; host_sel = sel; host_din = d; host_addr = a;
    host_cs_n = 1'b0; strobe(1'b0);
    if (rw) begin
      repeat (4) @(negedge clk);
      wait_rdy();
    end else repeat (2) @(negedge clk);
    q = host_dout;
    strobe(1'b1);
    repeat (4) @(negedge clk);
    wait_rdy();
    host_cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic port_reset(input logic rs);
    @(negedge clk);
    core_rs_n = rs; port_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    port_rst_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] q;
    logic [17:0] ea;
    int d0;
    rst_n = 1'b0; port_rst_n = 1'b0; mode_nonmux = 1'b0; host_cs_n = 1'b1;
    host_as_n = 1'b1; host_ds1_n = 1'b1; host_ds2_n = 1'b1; host_rw = 1'b1;
    host_sel = S_CTRL; host_addr = '0; host_din = '0; core_rs_n = 1'b1;
    dsp_hint_set = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    port_rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // reset state (R6, R5, R10)
    chk("R6 reset ready", host_rdy, 1);
    chk("R6 reset no request", mem_req, 0);
    chk("R5 reset host interrupt idle", host_int_n, 1);
    chk("R10 reset core held", core_hold, 1);
    chk("R4 reset no doorbell", dint_cnt, 0);

    // R1: address register write and read back
    foreach (ea[i]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [15:0] v;
      v = (k == 0) ? 16'h0000 : (k == 1) ? 16'h1234 : (k == 2) ? 16'hFFFF : 16'h8001;
      hacc(1'b0, S_ADDR, v, '0, q);
      hacc(1'b1, S_ADDR, '0, '0, q);
      chk("R1 address readback", q, v);
    end

    // R2, R11, R12: auto-increment sweep over all pages, with wrap
    for (int pg = 0; pg < 4; pg++) begin
      for (int b = 0; b < 2; b++) begin
        logic [15:0] base;
        base = b ? 16'hFFFE : 16'h0010;
        hacc(1'b0, S_CTRL, 16'(pg << 8), '0, q);
        hacc(1'b1, S_CTRL, '0, '0, q);
        chk("R11 page field readback", q, 32'(pg << 8));
        hacc(1'b0, S_ADDR, base, '0, q);
        for (int k = 0; k < 3; k++) begin
          hacc(1'b0, S_INC, base ^ 16'(k * 16'h0101), '0, q);
          ea = 18'({pg[1:0], base} + k);
          chk("R2 incremented write address", last_waddr, ea);
          chk("R12 write data", last_wdata, base ^ 16'(k * 16'h0101));
        end
        hacc(1'b1, S_ADDR, '0, '0, q);
        chk("R2 address after three steps", q, 16'(base + 3));
        hacc(1'b0, S_ADDR, base, '0, q);
        for (int k = 0; k < 3; k++) begin
          hacc(1'b1, S_INC, '0, '0, q);
          chk("R2 incremented read data", q, base ^ 16'(k * 16'h0101));
        end
      end
    end

    // R3: data access without increment
    hacc(1'b0, S_CTRL, 16'h0000, '0, q);
    hacc(1'b0, S_ADDR, 16'h0040, '0, q);
    hacc(1'b0, S_DATA, 16'hBEEF, '0, q);
    chk("R3 first write address", last_waddr, 18'h00040);
    hacc(1'b0, S_DATA, 16'hCAFE, '0, q);
    chk("R3 second write address", last_waddr, 18'h00040);
    hacc(1'b1, S_ADDR, '0, '0, q);
    chk("R3 address unchanged", q, 16'h0040);
    hacc(1'b1, S_DATA, '0, '0, q);
    chk("R3 read data", q, 16'hCAFE);

    // R6: exact timing of request and ready for a read of an unwritten word
    hacc(1'b0, S_ADDR, 16'h0101, '0, q);
    @(negedge clk);
    host_rw = 1'b1; host_sel = S_DATA; host_cs_n = 1'b0; host_ds1_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 no request before third edge", mem_req, 0);
    chk("R6 ready before third edge", host_rdy, 1);
    @(negedge clk);
    chk("R6 request at third edge", mem_req, 1);
    chk("R6 ready low while pending", host_rdy, 0);
    chk("R6 request is read", mem_we, 0);
    chk("R6 request address", mem_addr, 18'h00101);
    wait_rdy();
    chk("R6 read data from memory", host_dout, pattern(18'h00101));
    host_ds1_n = 1'b1;
    repeat (4) @(negedge clk);
    host_cs_n = 1'b1;
    @(negedge clk);

    // R4: DSP doorbell
    d0 = dint_cnt;
    hacc(1'b0, S_CTRL, 16'h0002, '0, q);
    chk("R4 doorbell pulse count", dint_cnt, d0 + 1);
    hacc(1'b1, S_CTRL, '0, '0, q);
    chk("R4 doorbell bit reads zero", q[1], 0);
    hacc(1'b0, S_CTRL, 16'h0000, '0, q);
    chk("R4 no pulse for zero", dint_cnt, d0 + 1);

    // R5: host doorbell
    @(negedge clk); dsp_hint_set = 1'b1;
    @(negedge clk); dsp_hint_set = 1'b0;
    @(negedge clk);
    chk("R5 host interrupt asserted", host_int_n, 0);
    hacc(1'b1, S_CTRL, '0, '0, q);
    chk("R5 status bit set", q[2], 1);
    hacc(1'b0, S_CTRL, 16'h0000, '0, q);
    chk("R5 zero write has no effect", host_int_n, 0);
    hacc(1'b0, S_CTRL, 16'h0004, '0, q);
    chk("R5 one write clears", host_int_n, 1);

    // R8: address strobe load
    @(negedge clk);
    host_cs_n = 1'b0; host_din = 16'h0777; host_as_n = 1'b0;
    repeat (2) @(negedge clk);
    host_as_n = 1'b1;
    repeat (4) @(negedge clk);
    host_cs_n = 1'b1;
    chk("R8 no memory access", mem_req, 0);
    hacc(1'b1, S_ADDR, '0, '0, q);
    chk("R8 address latched", q, 16'h0777);
    hacc(1'b0, S_INC, 16'h1111, '0, q);
    chk("R8 access at latched address", last_waddr, 18'h00777);

    // R7: separate-bus mode
    @(negedge clk); mode_nonmux = 1'b1;
    d0 = dint_cnt;
    hacc(1'b0, S_CTRL, 16'h0006, 18'h2ABCD, q);
    chk("R7 write at bus address", last_waddr, 18'h2ABCD);
    chk("R7 no doorbell from select", dint_cnt, d0);
    hacc(1'b1, S_ADDR, '0, 18'h2ABCD, q);
    chk("R7 read at bus address", q, 16'h0006);
    @(negedge clk); dsp_hint_set = 1'b1;
    @(negedge clk); dsp_hint_set = 1'b0;
    @(negedge clk);
    chk("R7 host interrupt unavailable", host_int_n, 1);

    // R10: core release in separate-bus mode
    hacc(1'b0, S_DATA, 16'h0000, 18'h00030, q);
    chk("R10 other address keeps hold", core_hold, 1);
    hacc(1'b0, S_DATA, 16'h1357, 18'h0002F, q);
    chk("R10 release address frees core", core_hold, 0);
    @(negedge clk); mode_nonmux = 1'b0;
    hacc(1'b1, S_ADDR, '0, '0, q);
    chk("R7 address register untouched", q, 16'h0778);

    // R10: port reset samples core reset level; release in shared-bus mode
    port_reset(1'b0);
    chk("R10 hold follows low core reset", core_hold, 0);
    port_reset(1'b1);
    chk("R10 hold follows high core reset", core_hold, 1);
    hacc(1'b0, S_ADDR, 16'h002F, '0, q);
    hacc(1'b0, S_DATA, 16'h0001, '0, q);
    chk("R10 shared-bus release", core_hold, 0);

    // R9: strobe end inside blackout is ignored; reset clears address
    hacc(1'b0, S_ADDR, 16'h4321, '0, q);
    @(negedge clk);
    port_rst_n = 1'b0; host_cs_n = 1'b0; host_rw = 1'b0; host_sel = S_ADDR;
    host_din = 16'h1234; host_ds1_n = 1'b0;
    repeat (4) @(negedge clk);
    port_rst_n = 1'b1;
    @(negedge clk);
    host_ds1_n = 1'b1;
    repeat (8) @(negedge clk);
    host_cs_n = 1'b1;
    @(negedge clk);
    hacc(1'b1, S_ADDR, '0, '0, q);
    chk("R9 blackout write ignored and address cleared", q, 16'h0000);
    hacc(1'b0, S_ADDR, 16'h00AA, '0, q);
    hacc(1'b1, S_ADDR, '0, '0, q);
    chk("R9 access accepted after blackout", q, 16'h00AA);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule